// File: doc/BRIEF.md
# Buffer Descriptor Ring Controller

The block moves bytes between a serial channel and buffers held in a small internal word memory. Software places a transmit ring and a receive ring of two-word descriptors in that memory. Word 0 of a descriptor holds the ownership flag, the wrap flag, the interrupt flag, an overrun flag and a 16-bit length. Word 1 holds the memory index where the buffer starts. Each buffer byte sits in the low byte of its own memory word. Software reads and writes the memory through a plain single-word port.

The transmit engine has the states TX_OFF, TX_WAIT, TX_FETCH, TX_BASE, TX_SEND and TX_CLOSE. Enabling it moves TX_OFF to TX_WAIT. TX_WAIT goes to TX_FETCH when the poll counter reaches the programmed period or when software pulses the demand strobe. TX_FETCH goes to TX_BASE if the descriptor is ready, and back to TX_WAIT if it is not. TX_BASE goes to TX_SEND, or straight to TX_CLOSE when the length is zero. TX_SEND goes to TX_CLOSE after the last byte. TX_CLOSE returns the descriptor to software and goes to TX_FETCH at the next ring position. Whenever no buffer data is on the line, the line carries a selectable idle byte.

The receive engine has the states RX_OFF, RX_PREFETCH, RX_BASE, RX_READY, RX_CLOSE, RX_DROP and RX_STARVED. Enabling it moves RX_OFF to RX_PREFETCH. RX_PREFETCH goes to RX_BASE if the descriptor is empty, and to RX_STARVED if it is not. RX_BASE goes to RX_READY. RX_READY goes to RX_CLOSE when the frame ends or the buffer overflows. RX_CLOSE goes to RX_DROP while the rest of an overrun frame is still arriving, and otherwise to RX_PREFETCH. RX_DROP and RX_STARVED both return to RX_PREFETCH at the end of a frame. Clearing an enable sends that engine to its OFF state and resets its ring pointer. Three sticky event bits, each with a mask, drive one interrupt line.

Top module: `bd_ring_ctrl`

## Requirements
- R1: After reset, tx_byte is 0xFF, tx_data_flag is 0, evt_status is 0 and irq is 0.
- R2: While no buffer byte is being sent, tx_byte is 0x7E if cfg_idle_flags is 1 and 0xFF if it is 0.
- R3: A waiting transmitter polls the descriptor at its ring pointer within cfg_poll_period cycles with no strobe, and within a few cycles of a tx_demand pulse.
- R4: A transmit descriptor whose word 0 bit 31 (ready) is clear sends nothing, and the ring pointer stays on it for the next poll.
- R5: A ready transmit descriptor sends the low byte of each of the next length (word 0 bits 15:0) memory words, starting at the index in word 1, in address order, with tx_data_flag high for each byte.
- R6: After the last byte, transmit word 0 is written back with bit 31 cleared and every other bit unchanged.
- R7: If word 0 bit 30 (wrap) of a descriptor is set, the next descriptor is the ring base. Otherwise the next descriptor is two words further on. This holds for both rings.
- R8: A received frame is stored one byte per word, starting at the prefetched word-1 index. At frame end, word 0 is rewritten with bit 31 (empty) cleared, bits 30 and 29 kept, bit 16 clear, and bits 15:0 equal to the byte count.
- R9: If a frame is longer than the length in the prefetched descriptor, bit 16 (overrun) is set and bits 15:0 hold the capacity. Nothing is written past the buffer, the rest of the frame is discarded, and the next frame goes to the next descriptor.
- R10: If a prefetched receive descriptor has bit 31 clear, event bit 2 (out of descriptors) is set. Frames are then discarded, and the prefetch is retried at each frame end.
- R11: Event bits (0 transmit done, 1 frame received, 2 out of descriptors) stay set until software writes a one to them through evt_clr. A new set wins over a clear in the same cycle.
- R12: irq is high exactly when some event bit and its evt_mask bit are both set.
- R13: Transmit-done and frame-received events are raised only for descriptors whose word 0 bit 29 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit engine enable |
| rx_en | input | 1 | Receive engine enable |
| cfg_idle_flags | input | 1 | Idle byte select: 1 sends 0x7E, 0 sends 0xFF |
| cfg_poll_period | input | POLL_W | Cycles between transmit ring polls |
| tx_demand | input | 1 | One-cycle strobe that forces an immediate poll |
| evt_clr | input | 3 | Write-one-to-clear strobes for the event bits |
| evt_mask | input | 3 | Interrupt mask for each event bit |
| sw_we | input | 1 | Software memory write enable |
| sw_addr | input | ADDR_W | Software memory word address |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Software read data, combinational |
| rx_valid | input | 1 | A receive byte is present this cycle |
| rx_byte | input | 8 | Receive byte |
| rx_last | input | 1 | This byte ends the frame |
| tx_byte | output | 8 | Line byte, registered |
| tx_data_flag | output | 1 | tx_byte carries buffer data |
| evt_status | output | 3 | Sticky event bits |
| irq | output | 1 | Interrupt request |

## Verification
The receive assertions assume that a frame's bytes start only when the engine sits in RX_READY, RX_DROP or RX_STARVED. In practice this means about three idle cycles separate the end of one frame from the start of the next, because closing and prefetching take that long. The stimulus keeps six idle cycles between frames and waits after enabling before it sends data. It also assumes that software never writes a word that an engine is writing in the same cycle. The bench only changes descriptors the engines do not own at that moment, or ones they are not scanning at that moment.

// File: rtl/bd_ring_pkg.sv
package bd_ring_pkg;
    localparam int unsigned DESC_RDY  = 31;
    localparam int unsigned DESC_WRAP = 30;
    localparam int unsigned DESC_IE   = 29;
    localparam int unsigned DESC_OVR  = 16;
    localparam int unsigned LEN_W     = 16;
    localparam int unsigned EV_W      = 3;
    localparam int unsigned EV_TXDONE = 0;
    localparam int unsigned EV_RXFRM  = 1;
    localparam int unsigned EV_NOBD   = 2;
    localparam logic [7:0]  IDLE_ONES = 8'hFF;
    localparam logic [7:0]  IDLE_FLAG = 8'h7E;

    typedef enum logic [2:0] {
        TX_OFF, TX_WAIT, TX_FETCH, TX_BASE, TX_SEND, TX_CLOSE
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_OFF, RX_PREFETCH, RX_BASE, RX_READY, RX_CLOSE, RX_DROP, RX_STARVED
    } rx_state_e;
endpackage

// File: rtl/bd_desc_mem.sv
module bd_desc_mem #(
    parameter int unsigned ADDR_W = 7
) (
    input  logic              clk,
    input  logic              sw_we,
    input  logic [ADDR_W-1:0] sw_addr,
    input  logic [31:0]       sw_wdata,
    output logic [31:0]       sw_rdata,
    input  logic [ADDR_W-1:0] tx_addr,
    input  logic              tx_we,
    input  logic [31:0]       tx_wdata,
    output logic [31:0]       tx_rdata,
    input  logic [ADDR_W-1:0] rx_addr,
    input  logic              rx_we,
    input  logic [31:0]       rx_wdata,
    output logic [31:0]       rx_rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [31:0] words_q [DEPTH];

    // Later writes win on a shared address: receive, then transmit, then software.
    always_ff @(posedge clk) begin
        if (sw_we) words_q[sw_addr] <= sw_wdata;
        if (tx_we) words_q[tx_addr] <= tx_wdata;
        if (rx_we) words_q[rx_addr] <= rx_wdata;
    end

    assign sw_rdata = words_q[sw_addr];
    assign tx_rdata = words_q[tx_addr];
    assign rx_rdata = words_q[rx_addr];
endmodule

// File: rtl/bd_tx_engine.sv
module bd_tx_engine
    import bd_ring_pkg::*;
#(
    parameter int unsigned ADDR_W    = 7,
    parameter int unsigned POLL_W    = 16,
    parameter int unsigned RING_BASE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              tx_demand,
    input  logic              cfg_idle_flags,
    input  logic [POLL_W-1:0] cfg_poll_period,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [31:0]       mem_rdata,
    output logic              mem_we,
    output logic [31:0]       mem_wdata,
    output logic [7:0]        tx_byte,
    output logic              tx_data_flag,
    output logic              done_o
);
    localparam logic [ADDR_W-1:0] BASE_A   = ADDR_W'(RING_BASE);
    localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] ONE_A    = ADDR_W'(1);
    localparam logic [POLL_W-1:0] POLL_ONE = POLL_W'(1);
    localparam logic [LEN_W-1:0]  LEN_ONE  = LEN_W'(1);

    tx_state_e         st_q, st_d;
    logic [POLL_W-1:0] poll_q;
    logic [LEN_W-1:0]  len_q, idx_q;
    logic [ADDR_W-1:0] ptr_q, buf_q;
    logic [31:0]       word_q;
    logic [7:0]        idle_byte;

    assign idle_byte = cfg_idle_flags ? IDLE_FLAG : IDLE_ONES;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TX_OFF:   if (tx_en) st_d = TX_WAIT;
            TX_WAIT:  if (tx_demand || poll_q >= cfg_poll_period) st_d = TX_FETCH;
            TX_FETCH: st_d = mem_rdata[DESC_RDY] ? TX_BASE : TX_WAIT;
            TX_BASE:  st_d = (len_q == '0) ? TX_CLOSE : TX_SEND;
            TX_SEND:  if (idx_q == len_q - LEN_ONE) st_d = TX_CLOSE;
            TX_CLOSE: st_d = TX_FETCH;
            default:  st_d = TX_OFF;
        endcase
        if (!tx_en) st_d = TX_OFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TX_OFF;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (st_q)
            TX_BASE: mem_addr = ptr_q + ONE_A;
            TX_SEND: mem_addr = buf_q + idx_q[ADDR_W-1:0];
            default: mem_addr = ptr_q;
        endcase
    end

    assign mem_we    = (st_q == TX_CLOSE);
    assign mem_wdata = {1'b0, word_q[30:0]};
    assign done_o    = (st_q == TX_CLOSE) && word_q[DESC_IE];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            poll_q       <= '0;
            len_q        <= '0;
            idx_q        <= '0;
            ptr_q        <= BASE_A;
            buf_q        <= '0;
            word_q       <= '0;
            tx_byte      <= IDLE_ONES;
            tx_data_flag <= 1'b0;
        end else begin
            poll_q <= (st_q == TX_WAIT) ? poll_q + POLL_ONE : '0;
            unique case (st_q)
                TX_OFF:   ptr_q <= BASE_A;
                TX_FETCH: begin
                    word_q <= mem_rdata;
                    len_q  <= mem_rdata[LEN_W-1:0];
                    idx_q  <= '0;
                end
                TX_BASE:  buf_q <= mem_rdata[ADDR_W-1:0];
                TX_SEND:  idx_q <= idx_q + LEN_ONE;
                TX_CLOSE: ptr_q <= word_q[DESC_WRAP] ? BASE_A : ptr_q + STEP;
                default:  ;
            endcase
            if (st_q == TX_SEND) begin
                tx_byte      <= mem_rdata[7:0];
                tx_data_flag <= 1'b1;
            end else begin
                tx_byte      <= idle_byte;
                tx_data_flag <= 1'b0;
            end
        end
    end

    // R2
    tx_idle_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TX_WAIT) |=> (!tx_data_flag &&
            tx_byte == ($past(cfg_idle_flags) ? IDLE_FLAG : IDLE_ONES)));

    // R5
    tx_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> !tx_data_flag);

    // R7
    tx_close_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TX_CLOSE && tx_en) |=> (st_q == TX_FETCH));
endmodule

// File: rtl/bd_rx_engine.sv
module bd_rx_engine
    import bd_ring_pkg::*;
#(
    parameter int unsigned ADDR_W    = 7,
    parameter int unsigned RING_BASE = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              rx_last,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [31:0]       mem_rdata,
    output logic              mem_we,
    output logic [31:0]       mem_wdata,
    output logic              frame_o,
    output logic              nobd_o
);
    localparam logic [ADDR_W-1:0] BASE_A  = ADDR_W'(RING_BASE);
    localparam logic [ADDR_W-1:0] STEP    = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] ONE_A   = ADDR_W'(1);
    localparam logic [LEN_W-1:0]  LEN_ONE = LEN_W'(1);

    rx_state_e         st_q, st_d;
    logic [ADDR_W-1:0] ptr_q, buf_q;
    logic [LEN_W-1:0]  cap_q, cnt_q;
    logic              wrap_q, ie_q, ovr_q, last_q;
    logic              full, frame_end;

    assign full      = (cnt_q == cap_q);
    assign frame_end = rx_valid && rx_last;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RX_OFF:      if (rx_en) st_d = RX_PREFETCH;
            RX_PREFETCH: st_d = mem_rdata[DESC_RDY] ? RX_BASE : RX_STARVED;
            RX_BASE:     st_d = RX_READY;
            RX_READY:    if (rx_valid && (full || rx_last)) st_d = RX_CLOSE;
            RX_CLOSE:    st_d = (ovr_q && !last_q && !frame_end) ? RX_DROP : RX_PREFETCH;
            RX_DROP,
            RX_STARVED:  if (frame_end) st_d = RX_PREFETCH;
            default:     st_d = RX_OFF;
        endcase
        if (!rx_en) st_d = RX_OFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RX_OFF;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (st_q)
            RX_BASE:  mem_addr = ptr_q + ONE_A;
            RX_READY: mem_addr = buf_q + cnt_q[ADDR_W-1:0];
            default:  mem_addr = ptr_q;
        endcase
        mem_we    = (st_q == RX_CLOSE) || (st_q == RX_READY && rx_valid && !full);
        mem_wdata = (st_q == RX_CLOSE) ? {1'b0, wrap_q, ie_q, 12'b0, ovr_q, cnt_q}
                                       : {24'b0, rx_byte};
    end

    assign frame_o = (st_q == RX_CLOSE) && ie_q;
    assign nobd_o  = (st_q == RX_PREFETCH) && !mem_rdata[DESC_RDY];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q  <= BASE_A;
            buf_q  <= '0;
            cap_q  <= '0;
            cnt_q  <= '0;
            wrap_q <= 1'b0;
            ie_q   <= 1'b0;
            ovr_q  <= 1'b0;
            last_q <= 1'b0;
        end else begin
            unique case (st_q)
                RX_OFF:      ptr_q <= BASE_A;
                RX_PREFETCH: begin
                    cap_q  <= mem_rdata[LEN_W-1:0];
                    wrap_q <= mem_rdata[DESC_WRAP];
                    ie_q   <= mem_rdata[DESC_IE];
                    cnt_q  <= '0;
                    ovr_q  <= 1'b0;
                    last_q <= 1'b0;
                end
                RX_BASE:     buf_q <= mem_rdata[ADDR_W-1:0];
                RX_READY:    if (rx_valid) begin
                    last_q <= rx_last;
                    if (full) ovr_q <= 1'b1;
                    else      cnt_q <= cnt_q + LEN_ONE;
                end
                RX_CLOSE:    ptr_q <= wrap_q ? BASE_A : ptr_q + STEP;
                default:     ;
            endcase
        end
    end

    // R10
    rx_starve_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nobd_o && rx_en) |=> (st_q == RX_STARVED));

    // R8
    rx_handback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RX_READY && frame_end && rx_en) |=> (st_q == RX_CLOSE));
endmodule

// File: rtl/bd_event_regs.sv
module bd_event_regs
    import bd_ring_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [EV_W-1:0] set_i,
    input  logic [EV_W-1:0] clr_i,
    input  logic [EV_W-1:0] mask_i,
    output logic [EV_W-1:0] evt_o,
    output logic            irq_o
);
    logic [EV_W-1:0] evt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= (evt_q & ~clr_i) | set_i;
    end

    assign evt_o = evt_q;
    assign irq_o = |(evt_q & mask_i);

    for (genvar i = 0; i < EV_W; i++) begin : g_ev_chk
        // R11
        evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (set_i[i] || (evt_q[i] && !clr_i[i])) |=> evt_q[i]);
        // R11
        evt_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_i[i]) |=> !evt_q[i]);
    end
endmodule

// File: rtl/bd_ring_ctrl.sv
module bd_ring_ctrl
    import bd_ring_pkg::*;
#(
    parameter int unsigned ADDR_W     = 7,
    parameter int unsigned POLL_W     = 16,
    parameter int unsigned TX_RING_AT = 0,
    parameter int unsigned RX_RING_AT = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic              cfg_idle_flags,
    input  logic [POLL_W-1:0] cfg_poll_period,
    input  logic              tx_demand,
    input  logic [2:0]        evt_clr,
    input  logic [2:0]        evt_mask,
    input  logic              sw_we,
    input  logic [ADDR_W-1:0] sw_addr,
    input  logic [31:0]       sw_wdata,
    output logic [31:0]       sw_rdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              rx_last,
    output logic [7:0]        tx_byte,
    output logic              tx_data_flag,
    output logic [2:0]        evt_status,
    output logic              irq
);
    logic [ADDR_W-1:0] tx_addr, rx_addr;
    logic [31:0]       tx_rdata, tx_wdata, rx_rdata, rx_wdata;
    logic              tx_we, rx_we, tx_done, rx_frame, rx_nobd;
    logic [EV_W-1:0]   ev_set;

    bd_desc_mem #(.ADDR_W(ADDR_W)) u_mem (
        .clk(clk),
        .sw_we(sw_we), .sw_addr(sw_addr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
        .tx_addr(tx_addr), .tx_we(tx_we), .tx_wdata(tx_wdata), .tx_rdata(tx_rdata),
        .rx_addr(rx_addr), .rx_we(rx_we), .rx_wdata(rx_wdata), .rx_rdata(rx_rdata)
    );

    bd_tx_engine #(.ADDR_W(ADDR_W), .POLL_W(POLL_W), .RING_BASE(TX_RING_AT)) u_tx (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_demand(tx_demand),
        .cfg_idle_flags(cfg_idle_flags), .cfg_poll_period(cfg_poll_period),
        .mem_addr(tx_addr), .mem_rdata(tx_rdata), .mem_we(tx_we), .mem_wdata(tx_wdata),
        .tx_byte(tx_byte), .tx_data_flag(tx_data_flag), .done_o(tx_done)
    );

    bd_rx_engine #(.ADDR_W(ADDR_W), .RING_BASE(RX_RING_AT)) u_rx (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_last(rx_last),
        .mem_addr(rx_addr), .mem_rdata(rx_rdata), .mem_we(rx_we), .mem_wdata(rx_wdata),
        .frame_o(rx_frame), .nobd_o(rx_nobd)
    );

    always_comb begin
        ev_set            = '0;
        ev_set[EV_TXDONE] = tx_done;
        ev_set[EV_RXFRM]  = rx_frame;
        ev_set[EV_NOBD]   = rx_nobd;
    end

    bd_event_regs u_ev (
        .clk(clk), .rst_n(rst_n), .set_i(ev_set), .clr_i(evt_clr), .mask_i(evt_mask),
        .evt_o(evt_status), .irq_o(irq)
    );
endmodule

// File: tb/bd_ring_ctrl_bench.sv
module bd_ring_ctrl_bench;
    localparam int AW = 7;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        tx_en = 0, rx_en = 0, cfg_idle_flags = 0, tx_demand = 0;
    logic [15:0] cfg_poll_period = 16'd1000;
    logic [2:0]  evt_clr = 0, evt_mask = 3'b111;
    logic        sw_we = 0;
    logic [AW-1:0] sw_addr = 0;
    logic [31:0] sw_wdata = 0, sw_rdata;
    logic        rx_valid = 0, rx_last = 0;
    logic [7:0]  rx_byte = 0, tx_byte;
    logic        tx_data_flag, irq;
    logic [2:0]  evt_status;

    bd_ring_ctrl u_bd_ring_ctrl (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en),
        .cfg_idle_flags(cfg_idle_flags), .cfg_poll_period(cfg_poll_period),
        .tx_demand(tx_demand), .evt_clr(evt_clr), .evt_mask(evt_mask),
        .sw_we(sw_we), .sw_addr(sw_addr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_last(rx_last),
        .tx_byte(tx_byte), .tx_data_flag(tx_data_flag), .evt_status(evt_status), .irq(irq)
    );

    always #10 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    logic [7:0] cap [256];
    int ncap = 0;

    always @(negedge clk) if (tx_data_flag && ncap < 256) begin
        cap[ncap] = tx_byte;
        ncap++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk); sw_we = 1; sw_addr = AW'(a); sw_wdata = d;
        @(negedge clk); sw_we = 0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk); sw_addr = AW'(a); #1 d = sw_rdata;
    endtask

    task automatic demand();
        @(negedge clk); tx_demand = 1;
        @(negedge clk); tx_demand = 0;
    endtask

    task automatic clear_evt();
        @(negedge clk); evt_clr = 3'b111;
        @(negedge clk); evt_clr = 3'b000;
    endtask

    task automatic wait_tx_done(input int slot, output int cycles);
        logic [31:0] v;
        cycles = 0;
        do begin rd(slot, v); cycles++; end while (v[31] && cycles < 300);
        repeat (3) @(negedge clk);
    endtask

    task automatic send_frame(input int n, input logic [7:0] seed);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); rx_valid = 1; rx_byte = seed + 8'(i); rx_last = (i == n - 1);
        end
        @(negedge clk); rx_valid = 0; rx_last = 0;
        repeat (6) @(negedge clk);
    endtask

    // {idle select, length, first byte}
    localparam logic [16:0] TXV [4] = '{
        {1'b0, 8'd3, 8'h10}, {1'b1, 8'd5, 8'h20}, {1'b0, 8'd1, 8'h30}, {1'b1, 8'd4, 8'h40}
    };

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        int start, cyc;
        repeat (3) @(negedge clk);
        // R1
        chk("R1 tx_byte", 32'(tx_byte), 32'hFF);
        chk("R1 data flag", 32'(tx_data_flag), 0);
        chk("R1 evt", 32'(evt_status), 0);
        chk("R1 irq", 32'(irq), 0);
        rst_n = 1;
        for (int a = 0; a < 128; a++) wr(a, 32'h0);
        tx_en = 1;

        for (int k = 0; k < 4; k++) begin
            int slot, bufa, len;
            logic [7:0] seed;
            logic       idl;
            idl  = TXV[k][16];
            len  = int'(TXV[k][15:8]);
            seed = TXV[k][7:0];
            slot = (k % 2) * 2;
            bufa = 64 + k * 8;
            cfg_idle_flags = idl;
            repeat (3) @(negedge clk);
            // R2
            chk("R2 idle byte", 32'(tx_byte), idl ? 32'h7E : 32'hFF);
            for (int i = 0; i < len; i++) wr(bufa + i, {24'h0, seed + 8'(i)});
            wr(slot + 1, 32'(bufa));
            wr(slot, 32'hA000_0000 | ((slot != 0) ? 32'h4000_0000 : 0) | 32'(len));
            start = ncap;
            demand();
            wait_tx_done(slot, cyc);
            // R3
            chk("R3 demand poll", 32'(cyc < 20), 1);
            // R5
            chk("R5 byte count", 32'(ncap - start), 32'(len));
            for (int i = 0; i < len; i++)
                chk("R5 byte value", 32'(cap[start + i]), 32'(seed + 8'(i)));
            rd(slot, v);
            // R6 R7
            chk("R6 handback word", v, 32'h2000_0000 | ((slot != 0) ? 32'h4000_0000 : 0) | 32'(len));
            // R13
            chk("R13 tx event", 32'(evt_status[0]), 1);
            // R2
            chk("R2 idle after frame", 32'(tx_byte), idl ? 32'h7E : 32'hFF);
            if (k == 0) begin
                // R12
                chk("R12 irq unmasked", 32'(irq), 1);
                evt_mask = 3'b000; @(negedge clk);
                chk("R12 irq masked", 32'(irq), 0);
                evt_mask = 3'b111; @(negedge clk);
                chk("R11 sticky", 32'(evt_status[0]), 1);
            end
            clear_evt();
            // R11
            chk("R11 w1c", 32'(evt_status), 0);
        end

        // R3 timer poll, R13 no event without interrupt flag; ring pointer is at slot 0 (R7)
        cfg_poll_period = 16'd20;
        wr(1, 32'd64);
        start = ncap;
        wr(0, 32'h8000_0002);
        wait_tx_done(0, cyc);
        chk("R3 timer poll latency", 32'(cyc < 50), 1);
        chk("R3 timer poll bytes", 32'(ncap - start), 2);
        chk("R7 wrap reuse byte", 32'(cap[start]), 32'h10);
        chk("R13 no tx event", 32'(evt_status[0]), 0);

        // R4 pointer now on slot 2, which is not ready
        cfg_poll_period = 16'd1000;
        repeat (25) @(negedge clk);
        start = ncap;
        demand();
        repeat (20) @(negedge clk);
        chk("R4 not ready sends nothing", 32'(ncap - start), 0);
        wr(3, 32'd72);
        wr(2, 32'hA000_0003);
        demand();
        wait_tx_done(2, cyc);
        chk("R4 same slot count", 32'(ncap - start), 3);
        chk("R4 same slot byte", 32'(cap[start + 2]), 32'h22);
        clear_evt();

        // Receive side
        wr(33, 32'd96);  wr(32, 32'hA000_0008);
        wr(35, 32'd104); wr(34, 32'hA000_0004);
        rx_en = 1;
        repeat (5) @(negedge clk);
        send_frame(3, 8'hA0);
        rd(32, v);   chk("R8 rx word", v, 32'h2000_0003);
        rd(96, v);   chk("R8 rx byte0", v, 32'hA0);
        rd(98, v);   chk("R8 rx byte2", v, 32'hA2);
        rd(99, v);   chk("R8 rx no extra", v, 0);
        chk("R8 rx event", 32'(evt_status), 3'b010);
        clear_evt();
        send_frame(6, 8'hB0);
        rd(34, v);   chk("R9 overrun word", v, 32'h2001_0004);
        rd(107, v);  chk("R9 last fitting byte", v, 32'hB3);
        rd(108, v);  chk("R9 no write past buffer", v, 0);
        // R10 slot 36 is empty of ownership
        chk("R10 nobd event", 32'(evt_status), 3'b110);
        clear_evt();
        send_frame(2, 8'hC0);
        chk("R10 retry at frame end", 32'(evt_status), 3'b100);
        rd(36, v);   chk("R10 dropped frame", v, 0);
        wr(37, 32'd112); wr(36, 32'hE000_0008);
        send_frame(1, 8'hD0);
        send_frame(2, 8'hE0);
        rd(36, v);   chk("R7 rx wrap word", v, 32'h6000_0002);
        rd(112, v);  chk("R10 frame after recovery", v, 32'hE0);
        wr(32, 32'hA000_0008);
        send_frame(1, 8'h55);
        send_frame(1, 8'hF0);
        rd(96, v);   chk("R7 rx wrap to base", v, 32'hF0);
        rd(32, v);   chk("R7 rx wrap base word", v, 32'h2000_0001);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule